// File: doc/BRIEF.md
# Interleaved Two-Phase Leading-Edge PWM Generator

This block produces two digital PWM outputs for a two-phase buck controller. The phases are interleaved by half a switching period. A free-running period counter sets the switching frequency. Each channel's falling edge comes from a termination event that fires once per period: channel A's event is at count zero, and channel B's event comes half a period later. The rising edge moves with the channel command. It is set by comparing the command against a sawtooth ramp, which is the period count re-referenced to that channel's termination instant.

After every falling edge the output is held low for at least a quarter of the period, whatever the command is. Partway through that forced off interval the block raises a one-cycle strobe, which tells an external current-sense path when to take its sample. Each channel latches its command at its own termination event, and the timebase latches the period at channel A's event. A mid-cycle change therefore takes effect only at the next boundary. The commands arrive already corrected for current balance.

The timebase state machine has two states. `TM_IDLE` holds the counter at zero, and the transition *start* (enable high) moves it to `TM_RUN`. `TM_RUN` counts and wraps, and the transition *halt* (enable low) returns it to `TM_IDLE`. Each channel state machine has four states: `CH_OFF`, `CH_BLANK`, `CH_ARMED` and `CH_ON`. Its transitions are:
- *terminate*: any state to `CH_BLANK` on a termination event.
- *unblank*: `CH_BLANK` to `CH_ARMED` when the quarter-period blanking count expires.
- *fire*: `CH_ARMED` to `CH_ON` when the ramp reaches the threshold.
- *drop*: any state to `CH_OFF` when the block is not running.

Top module: `ilv2_pwm`

## Requirements
- R1: While reset is asserted or enable is low, all four outputs are 0. The first running cycle after enable rises is count 0, a channel A termination event. Count k of the run is the k-th cycle after the enabling clock edge, starting from 0.
- R2: The switching period P is period_i latched when running starts and at each channel A termination. A value below 8 is treated as 8. Channel A terminates exactly once every P cycles.
- R3: pwm_a_o is 0 in the cycle after each channel A termination. Channel A's ramp equals the count.
- R4: Channel B terminates at count floor(P/2), and pwm_b_o is 0 in the following cycle. Channel B's ramp is (count - floor(P/2)) mod P. Channel B stays low until its first termination.
- R5: The threshold is T = P - cmd. The output is high in a cycle exactly when the channel's ramp in the previous cycle was at least T, so it is high for min(cmd, P - floor(P/4)) cycles per period.
- R6: A command of P - floor(P/4) or more saturates the threshold at T = floor(P/4). The output is therefore low for at least floor(P/4) cycles after each termination.
- R7: A command of 0 keeps the channel's output low for the whole period.
- R8: Each channel raises its sample strobe (samp_a_o or samp_b_o) for exactly one cycle per period, in the cycle whose ramp equals floor(P/8), while that channel is in its forced off interval.
- R9: A channel's command is latched only at its own termination event. A change at any other time has no effect until the next period of that channel.
- R10: When enable is sampled low, both PWM outputs and both strobes are 0 from the next cycle on, and the counter returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low stops the block and clears the counter |
| period_i | input | CNT_W | Switching period in clock cycles (minimum 8) |
| cmd_a_i | input | CNT_W | Channel A on-time command |
| cmd_b_i | input | CNT_W | Channel B on-time command |
| pwm_a_o | output | 1 | Channel A PWM output |
| pwm_b_o | output | 1 | Channel B PWM output |
| samp_a_o | output | 1 | Channel A current-sample strobe |
| samp_b_o | output | 1 | Channel B current-sample strobe |

## Verification
The bench compares all four outputs every cycle against a model built from the requirements. It runs an even period, an odd period and a period below the minimum. An odd period would show a wrong half-period offset as channel B falling one cycle early or late. A clamp error would show as a wrapping counter with no forced off time at all. Saturated and zero commands check the 75 percent duty ceiling and the never-firing case: a design without the quarter blanking would stay high almost the whole period, and a threshold comparison that underflows would fire on a zero command. A command changed midway through a period must not move that period's rising edge, which exposes a design that reads the command live. Disabling while an output is high must force it low on the very next cycle, and re-enabling must restart at count zero with channel A's termination.

// File: rtl/ilv2_pwm_pkg.sv
package ilv2_pwm_pkg;

    // Period timebase states
    typedef enum logic {
        TM_IDLE = 1'b0,
        TM_RUN  = 1'b1
    } tm_state_e;

    // Per-channel switching states
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_BLANK = 2'd1,
        CH_ARMED = 2'd2,
        CH_ON    = 2'd3
    } ch_state_e;

    // Number of interleaved phases
    localparam int unsigned NUM_PH = 2;

endpackage

// File: rtl/ilv2_timebase.sv
module ilv2_timebase
    import ilv2_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned P_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o
);

    localparam logic [CNT_W-1:0] PMIN_V = CNT_W'(P_MIN);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    tm_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] per_q, per_d;
    logic [CNT_W-1:0] per_clamped;

    // Periods below the minimum are raised to it
    assign per_clamped = (period_i < PMIN_V) ? PMIN_V : period_i;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            cnt_q   <= '0;
            per_q   <= PMIN_V;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            per_q   <= per_d;
        end
    end

    // Next state: start, count, wrap, halt
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        per_d   = per_q;
        unique case (state_q)
            TM_IDLE: begin
                cnt_d = '0;
                if (en_i) begin
                    state_d = TM_RUN;
                    per_d   = per_clamped;
                end
            end
            TM_RUN: begin
                if (!en_i) begin
                    state_d = TM_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == per_q - ONE_V) begin
                    cnt_d = '0;
                    per_d = per_clamped;
                end else begin
                    cnt_d = cnt_q + ONE_V;
                end
            end
            default: begin
                state_d = TM_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        run_o = (state_q == TM_RUN) && en_i;
        cnt_o = cnt_q;
        per_o = per_q;
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TM_RUN) |-> (cnt_q < per_q));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && cnt_q == per_q - ONE_V) |=> (cnt_q == '0));

    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0 && !run_o));

endmodule

// File: rtl/ilv2_phase_ramp.sv
module ilv2_phase_ramp #(
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned HALF_SHIFT = 0
) (
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] per_i,
    output logic [CNT_W-1:0] ramp_o,
    output logic             term_o
);

    logic [CNT_W-1:0] half;
    assign half = per_i >> 1;

    generate
        if (HALF_SHIFT == 0) begin : g_direct
            // Leading phase: ramp is the count itself
            assign ramp_o = cnt_i;
        end else begin : g_shifted
            // Lagging phase: count re-referenced half a period later
            assign ramp_o = (cnt_i >= half) ? (cnt_i - half)
                                            : (cnt_i + (per_i - half));
        end
    endgenerate

    assign term_o = run_i && (ramp_o == '0);

endmodule

// File: rtl/ilv2_channel.sv
module ilv2_channel
    import ilv2_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             term_i,
    input  logic [CNT_W-1:0] ramp_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] cmd_i,
    output logic             pwm_o,
    output logic             samp_o
);

    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] cmd_q, cmd_d;
    logic [CNT_W-1:0] per_q, per_d;
    logic [CNT_W-1:0] blk_q, blk_d;
    logic [CNT_W-1:0] quarter_q, eighth_q, quarter_in;
    logic [CNT_W:0]   thr;

    assign quarter_q  = per_q >> 2;
    assign eighth_q   = per_q >> 3;
    assign quarter_in = per_i >> 2;

    // Rising-edge threshold: zero command never fires, large commands saturate
    always_comb begin
        if (cmd_q == '0) begin
            thr = {1'b0, per_q};
        end else if (({1'b0, cmd_q} + {1'b0, quarter_q}) >= {1'b0, per_q}) begin
            thr = {1'b0, quarter_q};
        end else begin
            thr = {1'b0, per_q} - {1'b0, cmd_q};
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_OFF;
            cmd_q <= '0;
            per_q <= CNT_W'(8);
            blk_q <= '0;
        end else begin
            st_q  <= st_d;
            cmd_q <= cmd_d;
            per_q <= per_d;
            blk_q <= blk_d;
        end
    end

    // Next state: terminate, unblank, fire, drop
    always_comb begin
        st_d  = st_q;
        cmd_d = cmd_q;
        per_d = per_q;
        blk_d = blk_q;
        if (!run_i) begin
            st_d  = CH_OFF;
            blk_d = '0;
        end else if (term_i) begin
            st_d  = CH_BLANK;
            cmd_d = cmd_i;
            per_d = per_i;
            blk_d = quarter_in - ONE_V;
        end else begin
            unique case (st_q)
                CH_OFF:   st_d = CH_OFF;
                CH_BLANK: begin
                    if (blk_q <= ONE_V) begin
                        st_d  = CH_ARMED;
                        blk_d = '0;
                    end else begin
                        blk_d = blk_q - ONE_V;
                    end
                end
                CH_ARMED: begin
                    if ({1'b0, ramp_i} >= thr) st_d = CH_ON;
                end
                CH_ON:    st_d = CH_ON;
                default:  st_d = CH_OFF;
            endcase
        end
    end

    // Outputs from state
    always_comb begin
        pwm_o  = (st_q == CH_ON);
        samp_o = (st_q == CH_BLANK) && (blk_q == quarter_q - eighth_q);
    end

    // Low-time tracker used only by the minimum off-time check
    logic [CNT_W:0] off_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run_q <= '0;
        end else if (run_i && term_i) begin
            off_run_q <= '0;
        end else if (!pwm_o && !(&off_run_q)) begin
            off_run_q <= off_run_q + 1'b1;
        end
    end

    assert_fall_at_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && term_i) |=> !pwm_o);

    assert_min_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> (off_run_q >= {1'b0, quarter_q}));

    assert_zero_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ARMED && cmd_q == '0 && run_i && !term_i) |=> !pwm_o);

    assert_samp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        samp_o |=> !samp_o);

    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !term_i) |=> $stable(cmd_q));

    assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!pwm_o && !samp_o));

endmodule

// File: rtl/ilv2_pwm.sv
module ilv2_pwm
    import ilv2_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned P_MIN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmd_a_i,
    input  logic [CNT_W-1:0] cmd_b_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic             samp_a_o,
    output logic             samp_b_o
);

    logic             run_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] per_w;

    logic [CNT_W-1:0] cmd_w  [NUM_PH];
    logic [CNT_W-1:0] ramp_w [NUM_PH];
    logic [NUM_PH-1:0] term_w;
    logic [NUM_PH-1:0] pwm_w;
    logic [NUM_PH-1:0] samp_w;

    assign cmd_w[0] = cmd_a_i;
    assign cmd_w[1] = cmd_b_i;

    ilv2_timebase #(
        .CNT_W (CNT_W),
        .P_MIN (P_MIN)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .period_i (period_i),
        .run_o    (run_w),
        .cnt_o    (cnt_w),
        .per_o    (per_w)
    );

    generate
        for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
            ilv2_phase_ramp #(
                .CNT_W      (CNT_W),
                .HALF_SHIFT (g)
            ) u_ramp (
                .run_i  (run_w),
                .cnt_i  (cnt_w),
                .per_i  (per_w),
                .ramp_o (ramp_w[g]),
                .term_o (term_w[g])
            );

            ilv2_channel #(
                .CNT_W (CNT_W)
            ) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .run_i  (run_w),
                .term_i (term_w[g]),
                .ramp_i (ramp_w[g]),
                .per_i  (per_w),
                .cmd_i  (cmd_w[g]),
                .pwm_o  (pwm_w[g]),
                .samp_o (samp_w[g])
            );
        end
    endgenerate

    assign pwm_a_o  = pwm_w[0];
    assign pwm_b_o  = pwm_w[1];
    assign samp_a_o = samp_w[0];
    assign samp_b_o = samp_w[1];

    assert_terms_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(term_w[0] && term_w[1]));

    assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (pwm_w == '0 && samp_w == '0));

endmodule

// File: tb/ilv2_pwm_tb_top.sv
module ilv2_pwm_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en_i;
    logic [CNT_W-1:0] period_i;
    logic [CNT_W-1:0] cmd_a_i;
    logic [CNT_W-1:0] cmd_b_i;
    logic             pwm_a_o, pwm_b_o, samp_a_o, samp_b_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv2_pwm #(.CNT_W(CNT_W), .P_MIN(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .period_i (period_i),
        .cmd_a_i  (cmd_a_i),
        .cmd_b_i  (cmd_b_i),
        .pwm_a_o  (pwm_a_o),
        .pwm_b_o  (pwm_b_o),
        .samp_a_o (samp_a_o),
        .samp_b_o (samp_b_o)
    );

    task automatic chk(logic got, logic exp, string req, string what, int k);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s count %0d: actual %0b expected %0b", req, what, k, got, exp);
        end
    endtask

    // Threshold from R5/R6/R7
    function automatic int thr_of(int cmd, int p);
        int q = p / 4;
        if (cmd == 0) return p;
        if (cmd + q >= p) return q;
        return p - cmd;
    endfunction

    task automatic all_low(string req, int k);
        chk(pwm_a_o,  1'b0, req, "pwm_a",  k);
        chk(pwm_b_o,  1'b0, req, "pwm_b",  k);
        chk(samp_a_o, 1'b0, req, "samp_a", k);
        chk(samp_b_o, 1'b0, req, "samp_b", k);
    endtask

    // Enable, compare every cycle against the requirement model, optional mid-run
    // change of channel A command, then disable and check R10.
    task automatic run_window(int p_in, int c1, int c2, int ncyc,
                              int chg_at, int chg_val, string tag);
        int p    = (p_in < 8) ? 8 : p_in;
        int half = p / 2;
        int e    = p / 8;
        int lat1 = 0, lat2 = 0;
        bit st1 = 0, st2 = 0;
        period_i = CNT_W'(p_in);
        cmd_a_i  = CNT_W'(c1);
        cmd_b_i  = CNT_W'(c2);
        en_i     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < ncyc; k++) begin
            int r1 = k % p;
            int r2 = (k + p - half) % p;
            logic e_p1 = st1 && (((r1 + p - 1) % p) >= thr_of(lat1, p));
            logic e_p2 = st2 && (((r2 + p - 1) % p) >= thr_of(lat2, p));
            chk(pwm_a_o,  e_p1, tag, "pwm_a",  k);
            chk(pwm_b_o,  e_p2, tag, "pwm_b",  k);
            chk(samp_a_o, st1 && (r1 == e), tag, "samp_a", k);
            chk(samp_b_o, st2 && (r2 == e), tag, "samp_b", k);
            if (k == chg_at) cmd_a_i = CNT_W'(chg_val);
            if (r1 == 0) begin lat1 = int'(cmd_a_i); st1 = 1'b1; end
            if (r2 == 0 && k >= half) begin lat2 = int'(cmd_b_i); st2 = 1'b1; end
            @(negedge clk);
        end
        en_i = 1'b0;
        @(negedge clk);
        all_low("R10", ncyc + 1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en_i = 1'b0; period_i = '0; cmd_a_i = '0; cmd_b_i = '0;
        repeat (3) @(negedge clk);
        all_low("R1 in reset", 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        all_low("R1 enable low", 0);
    endtask

    // Even period, mid-range commands: edges, offset, duty, strobes
    task automatic t_basic();
        run_window(16, 6, 10, 53, -1, 0, "R3/R4/R5/R8 basic");
    endtask

    // Commands beyond the ceiling: 75 percent duty
    task automatic t_saturate();
        run_window(16, 15, 200, 53, -1, 0, "R6 saturate");
    endtask

    // Zero command on channel A, small command on B
    task automatic t_zero();
        run_window(16, 0, 3, 53, -1, 0, "R7 zero");
    endtask

    // Odd period: floor of half, quarter, eighth
    task automatic t_odd();
        run_window(13, 5, 9, 44, -1, 0, "R2/R5 odd");
    endtask

    // Period below the minimum is clamped to 8
    task automatic t_clamp();
        run_window(3, 4, 7, 29, -1, 0, "R2 clamp");
    endtask

    // Command change mid-period must wait for the next termination
    task automatic t_latch();
        run_window(16, 4, 8, 53, 20, 12, "R9 latch");
    endtask

    // Disable while channel A is high, then restart from count zero
    task automatic t_disable();
        run_window(16, 10, 5, 26, -1, 0, "R10 disable");
        run_window(16, 10, 5, 20, -1, 0, "R1 restart");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_basic();
        t_saturate();
        t_zero();
        t_odd();
        t_clamp();
        t_latch();
        t_disable();
        summary();
    end

endmodule